// File: doc/BRIEF.md
# Hidden DAC Register Unlock Sequencer

This block sits on the pixel-mask port of a VGA-style colour DAC and guards an extra 8-bit register behind that port. Software reaches the register through back-to-back reads of the mask port. Each read advances an access counter. The read that takes the counter to five returns the hidden byte and clears the counter. A write issued while the counter holds four stores its byte into the hidden register. Every other read returns 0xFF. The normal mask function and the palette RAM belong to neighbouring blocks. The block only counts accesses, supplies the read data for mask reads and holds the hidden byte on `hidden_o` for the display pipeline.

The counter leaves reset at five. While it is at that value, reads cannot unlock the register until a write or an access to another DAC port sets the counter back to zero. Read data is combinational: it is valid in the same cycle as the read strobe. The hidden byte changes on the clock edge that ends the qualifying write.

Top module: `hdac_unlock`

## Requirements
- R1: `rdata_o` is 8'hFF in every cycle except one in which an effective mask read takes the counter to five, including idle cycles.
- R2: An effective mask read first adds one to the counter. If the result is five, `rdata_o` shows `hidden_o` in that same cycle and the counter becomes zero at the edge. Otherwise the counter keeps the incremented value.
- R3: A mask write while the counter equals four stores `wdata_i` into the hidden register, visible on `hidden_o` after that clock edge.
- R4: Every mask write clears the counter to zero. A write at any other count leaves `hidden_o` unchanged.
- R5: Reset (active-low, asynchronous) sets the counter to five and `hidden_o` to 8'h00. Reads that follow reset therefore return 8'hFF until a write or another-port access occurs.
- R6: An access to another DAC port (`other_acc_i`) clears the counter to zero without changing `hidden_o`.
- R7: The 3-bit counter saturates at seven and never wraps back to zero through reads.
- R8: When strobes coincide, the write wins over the other-port access, which wins over the read. A read that loses does not advance the counter and returns 8'hFF.
- R9: `hidden_o` changes only on the edge that ends a mask write made while the counter equals four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mask_rd_i | input | 1 | Read strobe of the pixel-mask port |
| mask_wr_i | input | 1 | Write strobe of the pixel-mask port |
| other_acc_i | input | 1 | Any access to another DAC port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the mask port |
| hidden_o | output | 8 | Current hidden register value |

## Verification
The hardest states to reach are the counter values that differ from the usual count of zero to four. These are the locked value of five left by reset and the saturated value of seven, where extra reads must keep returning 0xFF instead of wrapping around into the unlock window. The vector table starts directly after reset and reads three times, which drives the counter through six into saturation. A write then recovers the counter, and the table checks that this write left the hidden byte untouched. Later rows place coincident strobes exactly at count four, so that the priority order decides whether the hidden byte is written or revealed. A reset issued in the middle of a sequence then shows that the lock returns.

// File: rtl/hdac_pkg.sv
package hdac_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned CNT_W      = 3;
  localparam int unsigned UNLOCK_CNT = 5;
  localparam int unsigned RESET_CNT  = 5;

  // Resolved access for one cycle after priority.
  typedef struct packed {
    logic wr;   // mask write wins
    logic clr;  // counter clear (write or other port)
    logic rd;   // effective mask read
  } acc_t;
endpackage

// File: rtl/hdac_acc_dec.sv
module hdac_acc_dec
  import hdac_pkg::*;
(
  input  logic mask_rd_i,
  input  logic mask_wr_i,
  input  logic other_acc_i,
  output acc_t acc_o
);
  always_comb begin
    acc_o.wr  = mask_wr_i;
    acc_o.clr = mask_wr_i | other_acc_i;
    acc_o.rd  = mask_rd_i & ~mask_wr_i & ~other_acc_i;
  end
endmodule

// File: rtl/hdac_seq_cnt.sv
module hdac_seq_cnt #(
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned UNLOCK_CNT = 5,
  parameter int unsigned RESET_CNT  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             arm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(UNLOCK_CNT);
  localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(UNLOCK_CNT - 1);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(RESET_CNT);

  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;

  // saturating pre-increment
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign hit_o   = rd_i && (cnt_inc == CNT_HIT);
  assign arm_o   = (cnt_q == CNT_ARM);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (hit_o) cnt_d = '0;
    else if (rd_i)  cnt_d = cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_RST;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hdac_shadow_reg.sv
module hdac_shadow_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/hdac_rd_mux.sv
module hdac_rd_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sel_i,
  input  logic [DATA_W-1:0] hidden_i,
  output logic [DATA_W-1:0] rdata_o
);
  assign rdata_o = sel_i ? hidden_i : {DATA_W{1'b1}};
endmodule

// File: rtl/hdac_unlock.sv
module hdac_unlock
  import hdac_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_rd_i,
  input  logic          mask_wr_i,
  input  logic          other_acc_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] hidden_o
);
  acc_t          acc;
  logic [CW-1:0] cnt_q;
  logic          hit, arm;

  hdac_acc_dec u_dec (
    .mask_rd_i  (mask_rd_i),
    .mask_wr_i  (mask_wr_i),
    .other_acc_i(other_acc_i),
    .acc_o      (acc)
  );

  hdac_seq_cnt #(
    .CNT_W     (CW),
    .UNLOCK_CNT(UNLOCK_CNT),
    .RESET_CNT (RESET_CNT)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rd_i  (acc.rd),
    .clr_i (acc.clr),
    .cnt_o (cnt_q),
    .hit_o (hit),
    .arm_o (arm)
  );

  hdac_shadow_reg #(.DATA_W(DW)) u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (acc.wr && arm),
    .d_i   (wdata_i),
    .q_o   (hidden_o)
  );

  hdac_rd_mux #(.DATA_W(DW)) u_mux (
    .sel_i   (hit),
    .hidden_i(hidden_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/hdac_unlock_chk.sv
module hdac_unlock_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mask_rd_i,
  input logic          mask_wr_i,
  input logic          other_acc_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] hidden_o,
  input logic [CW-1:0] cnt_i
);
  logic rd_only;
  assign rd_only = mask_rd_i && !mask_wr_i && !other_acc_i;

  assert_unlock_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && cnt_i == CW'(4)) |-> (rdata_o == hidden_o));
  assert_unlock_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && cnt_i == CW'(4)) |=> (cnt_i == '0));
  assert_locked_ff_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_only && cnt_i == CW'(4)) |-> (rdata_o == {DW{1'b1}}));
  assert_write_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && cnt_i == CW'(4)) |=> (hidden_o == $past(wdata_i)));
  assert_write_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> (cnt_i == '0));
  assert_other_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_acc_i |=> (cnt_i == '0));
  assert_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && cnt_i == {CW{1'b1}}) |=> (cnt_i == {CW{1'b1}}));
  assert_hidden_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_i && cnt_i == CW'(4)) |=> $stable(hidden_o));
  assert_lost_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_rd_i && (mask_wr_i || other_acc_i)) |-> (rdata_o == {DW{1'b1}}));
endmodule

bind hdac_unlock hdac_unlock_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mask_rd_i  (mask_rd_i),
  .mask_wr_i  (mask_wr_i),
  .other_acc_i(other_acc_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .hidden_o   (hidden_o),
  .cnt_i      (cnt_q)
);

// File: tb/tb_hdac_unlock.sv
module tb_hdac_unlock;
  localparam int CLK_PERIOD = 10;
  localparam int N = 41;
  localparam logic [2:0] IDL = 3'd0, RD = 3'd1, WR = 3'd2, OTH = 3'd3,
                         RDWR = 3'd4, RDOTH = 3'd5;

  // {op, wdata, expected rdata, expected hidden after edge}
  localparam logic [26:0] VEC [N] = '{
    {RD,  8'h00, 8'hFF, 8'h00},  // R5 locked: 5->6
    {RD,  8'h00, 8'hFF, 8'h00},  // R7 6->7
    {RD,  8'h00, 8'hFF, 8'h00},  // R7 saturated
    {WR,  8'h11, 8'hFF, 8'h00},  // R4 write at 7: no store, clear
    {RD,  8'h00, 8'hFF, 8'h00},  // R1
    {RD,  8'h00, 8'hFF, 8'h00},
    {RD,  8'h00, 8'hFF, 8'h00},
    {RD,  8'h00, 8'hFF, 8'h00},  // count 4
    {WR,  8'hA5, 8'hFF, 8'hA5},  // R3 store
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hA5, 8'hA5},  // R2 fifth read
    {RD,  8'h00, 8'hFF, 8'hA5},  // R1 after unlock
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {OTH, 8'h00, 8'hFF, 8'hA5},  // R6 clear
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RDOTH, 8'h00, 8'hFF, 8'hA5}, // R8 other wins
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RD,  8'h00, 8'hFF, 8'hA5},
    {RDWR, 8'h3C, 8'hFF, 8'h3C},  // R8 write wins, stores
    {RD,  8'h00, 8'hFF, 8'h3C},
    {RD,  8'h00, 8'hFF, 8'h3C},
    {RD,  8'h00, 8'hFF, 8'h3C},
    {RD,  8'h00, 8'hFF, 8'h3C},
    {RD,  8'h00, 8'h3C, 8'h3C},  // R2
    {RD,  8'h00, 8'hFF, 8'h3C},
    {RD,  8'h00, 8'hFF, 8'h3C},
    {RD,  8'h00, 8'hFF, 8'h3C},
    {RD,  8'h00, 8'hFF, 8'h3C},
    {IDL, 8'h00, 8'hFF, 8'h3C},  // R1 idle holds count
    {RD,  8'h00, 8'h3C, 8'h3C},  // R2
    {WR,  8'h77, 8'hFF, 8'h3C}   // R9 write at 0 ignored
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mask_rd = 1'b0, mask_wr = 1'b0, other_acc = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, hidden;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdac_unlock dut (
    .clk_i(clk), .rst_ni(rst_ni), .mask_rd_i(mask_rd), .mask_wr_i(mask_wr),
    .other_acc_i(other_acc), .wdata_i(wdata), .rdata_o(rdata), .hidden_o(hidden)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] wd,
                      input logic [7:0] exp_rd, input logic [7:0] exp_hid, input string req);
    @(negedge clk);
    mask_rd   = (op == RD) || (op == RDWR) || (op == RDOTH);
    mask_wr   = (op == WR) || (op == RDWR);
    other_acc = (op == OTH) || (op == RDOTH);
    wdata     = wd;
    #1 check({req, " rdata"}, rdata, exp_rd);
    @(posedge clk);
    #1;
    mask_rd = 1'b0; mask_wr = 1'b0; other_acc = 1'b0; wdata = 8'h00;
    check({req, " hidden"}, hidden, exp_hid);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD*2 + 3);
    check("R5 reset hidden", hidden, 8'h00);
    check("R1 reset idle rdata", rdata, 8'hFF);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < N; i++)
      step(VEC[i][26:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], $sformatf("row%0d", i));

    // R5: reset in mid-sequence re-locks and clears hidden
    for (int i = 0; i < 4; i++) step(RD, 8'h00, 8'hFF, 8'h3C, "R1 pre-reset");
    @(negedge clk) rst_ni = 1'b0;
    #1 check("R5 hidden after reset", hidden, 8'h00);
    @(negedge clk) rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) step(RD, 8'h00, 8'hFF, 8'h00, "R5 locked after reset");
    step(WR, 8'h5A, 8'hFF, 8'h00, "R4 write at saturation");
    for (int i = 0; i < 4; i++) step(RD, 8'h00, 8'hFF, 8'h00, "R2 count up");
    step(WR, 8'h5A, 8'hFF, 8'h5A, "R3 store after reset");
    finish_run();
  end
endmodule